// File: doc/BRIEF.md
# NAND Program and Erase Sequencer

This block sits on the host side of a small-page NAND bus. It accepts a program or erase request on a valid/ready port and drives the bus through the whole operation. For a program it writes the setup command, one column address cycle, two row address cycles, then the payload taken from a byte stream, and then the confirm command. For an erase it writes the erase setup command, two block address cycles and the erase confirm. It then waits while the device holds R/B low. It reads the status byte and gives one response: pass or fail, with the block index, so that a failing block can be retired by the layer above.

The sequencer also keeps a small table of partial-program counts, one count per page. A page that has already had ten programs since its block was last erased is refused with no bus activity. A request that arrives while the write-protect input is low is refused in the same way. Each bus cycle appears as a one-clock write strobe, qualified by a command-latch flag or an address-latch flag. The status byte is fetched with a one-clock read strobe.

Top module: `nand_pe_seq`

## Requirements
- R1: A program request emits, in this order: command 80h (busCle=1), the column byte, row bits [7:0], row bits [15:8] (busAle=1 on all three), each payload byte in arrival order (both latch flags 0), then command 10h (busCle=1). The row is {block, page}, with the page in the low 4 bits, zero-extended to 16 bits.
- R2: An erase request emits command 60h, then two address cycles carrying bits [7:0] and [15:8] of {block, 4'b0000}, then command D0h.
- R3: After a confirm command, the bus stays silent (busWe=0) until nandRbN is high again. Exactly one 70h command and then one busRe pulse follow.
- R4: The response is a single-cycle rspValid with rspBlock equal to the request's block. rspCode is 0 (pass) when status bit 0 is 0 and 1 (fail) when status bit 0 is 1.
- R5: A request accepted while nandWpN is low responds in the cycle after acceptance with rspCode 2 and produces no bus cycle.
- R6: A program of a page that has already had ten programs since its block's last erase responds at once with rspCode 3 and produces no bus cycle. Other pages are unaffected.
- R7: An erase that is started clears the program counts of all 16 pages of that block, whatever its status result.
- R8: A refused request leaves the counts unchanged: a refused program adds no count, and an erase refused for write protect clears nothing.
- R9: dataReady is high only during the payload phase of a program. The byte accepted with dataLast is the last payload byte sent.
- R10: reqReady is high only while no operation is in progress. No bus cycle has busCle and busAle high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request taken on valid and ready |
| reqErase | input | 1 | 1 = erase block, 0 = program page |
| reqBlock | input | BLK_W | Block index |
| reqPage | input | 4 | Page within the block |
| reqCol | input | 8 | Start column for a program |
| dataValid | input | 1 | Payload byte offered |
| dataReady | output | 1 | Payload byte taken on valid and ready |
| dataByte | input | 8 | Payload byte |
| dataLast | input | 1 | Marks the final payload byte |
| busCle | output | 1 | Command latch qualifier of the current bus cycle |
| busAle | output | 1 | Address latch qualifier of the current bus cycle |
| busWe | output | 1 | One-clock write strobe of a bus cycle |
| busRe | output | 1 | One-clock read strobe for the status byte |
| busDout | output | 8 | Byte driven onto the bus |
| busDin | input | 8 | Byte returned by the device, valid with busRe |
| nandRbN | input | 1 | Device ready (1) or busy (0) |
| nandWpN | input | 1 | Write protect, low refuses requests |
| rspValid | output | 1 | One-cycle completion pulse |
| rspCode | output | 2 | 0 pass, 1 fail, 2 protected, 3 limit reached |
| rspBlock | output | BLK_W | Block of the completed request |

## Verification
The bench sends long runs of programs to one page to reach the tenth and eleventh program. This shows whether the count table refuses at the right point. Erases and write-protected erases placed between those runs show whether a refused erase clears counts it should not. Random mixes then spread requests over a few blocks and pages, with random status failures, random busy lengths and random gaps in the payload stream. Each bus trace is compared byte for byte with the expected command, address and payload order, so a swapped address byte, a lost payload byte or an early status read each shows up as a mismatch.

// File: rtl/nand_pe_seq_pkg.sv
package nand_pe_seq_pkg;

  typedef enum logic [1:0] {
    RSP_PASS  = 2'd0,
    RSP_FAIL  = 2'd1,
    RSP_WPROT = 2'd2,
    RSP_LIMIT = 2'd3
  } rspCode_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_CMD  = 2'd1,
    BUS_ADDR = 2'd2,
    BUS_DATA = 2'd3
  } busKind_e;

  typedef enum logic [1:0] {
    CMD_SETUP   = 2'd0,
    CMD_CONFIRM = 2'd1,
    CMD_STATUS  = 2'd2
  } cmdSel_e;

  localparam logic [7:0] OPC_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OPC_PROG_GO     = 8'h10;
  localparam logic [7:0] OPC_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OPC_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OPC_STATUS      = 8'h70;

  typedef struct packed {
    logic     load;
    logic     bump;
    logic     wipe;
    logic     setReject;
    rspCode_e rejectCode;
    busKind_e kind;
    cmdSel_e  cmd;
    logic [1:0] addrIdx;
    logic     readStat;
  } ctrlStrobe_t;

endpackage

// File: rtl/nand_pe_seq_ctrl.sv
module nand_pe_seq_ctrl
  import nand_pe_seq_pkg::*;
#(
  parameter int GUARD_CYC = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqErase,
  input  logic        wpN,
  input  logic        limitHit,
  input  logic        opErase,
  input  logic        dataValid,
  input  logic        dataLast,
  input  logic        rbN,
  output logic        reqReady,
  output logic        dataReady,
  output logic        rspValid,
  output ctrlStrobe_t stb
);

  localparam int GW = (GUARD_CYC < 2) ? 1 : $clog2(GUARD_CYC);
  localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD_CYC - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_DATA, ST_CONFIRM, ST_GUARD,
    ST_WAITRDY, ST_STATCMD, ST_STATRD, ST_STATCAP, ST_RESP
  } state_e;

  state_e state, stateNext;
  logic [1:0] addrCnt, addrCntNext;
  logic [GW-1:0] guardCnt, guardCntNext;
  logic addrLast;

  assign addrLast  = opErase ? (addrCnt == 2'd1) : (addrCnt == 2'd2);
  assign reqReady  = (state == ST_IDLE);
  assign dataReady = (state == ST_DATA);
  assign rspValid  = (state == ST_RESP);

  always_comb begin
    stateNext    = state;
    addrCntNext  = addrCnt;
    guardCntNext = guardCnt;
    stb          = '0;
    stb.rejectCode = RSP_PASS;
    stb.kind     = BUS_IDLE;
    stb.cmd      = CMD_SETUP;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stb.load = 1'b1;
        if (!wpN) begin
          stb.setReject  = 1'b1;
          stb.rejectCode = RSP_WPROT;
          stateNext      = ST_RESP;
        end else if (!reqErase && limitHit) begin
          stb.setReject  = 1'b1;
          stb.rejectCode = RSP_LIMIT;
          stateNext      = ST_RESP;
        end else begin
          stb.bump  = !reqErase;
          stb.wipe  = reqErase;
          stateNext = ST_SETUP;
        end
      end
      ST_SETUP: begin
        stb.kind    = BUS_CMD;
        stb.cmd     = CMD_SETUP;
        addrCntNext = '0;
        stateNext   = ST_ADDR;
      end
      ST_ADDR: begin
        stb.kind    = BUS_ADDR;
        stb.addrIdx = addrCnt;
        addrCntNext = addrCnt + 2'd1;
        if (addrLast) stateNext = opErase ? ST_CONFIRM : ST_DATA;
      end
      ST_DATA: if (dataValid) begin
        stb.kind = BUS_DATA;
        if (dataLast) stateNext = ST_CONFIRM;
      end
      ST_CONFIRM: begin
        stb.kind     = BUS_CMD;
        stb.cmd      = CMD_CONFIRM;
        guardCntNext = '0;
        stateNext    = ST_GUARD;
      end
      ST_GUARD: begin
        guardCntNext = guardCnt + 1'b1;
        if (guardCnt == GUARD_LAST) stateNext = ST_WAITRDY;
      end
      ST_WAITRDY: if (rbN) stateNext = ST_STATCMD;
      ST_STATCMD: begin
        stb.kind  = BUS_CMD;
        stb.cmd   = CMD_STATUS;
        stateNext = ST_STATRD;
      end
      ST_STATRD: begin
        stb.readStat = 1'b1;
        stateNext    = ST_STATCAP;
      end
      ST_STATCAP: stateNext = ST_RESP;
      ST_RESP:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      addrCnt  <= '0;
      guardCnt <= '0;
    end else begin
      state    <= stateNext;
      addrCnt  <= addrCntNext;
      guardCnt <= guardCntNext;
    end
  end

endmodule

// File: rtl/nand_pe_seq_dp.sv
module nand_pe_seq_dp
  import nand_pe_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int PP_LIMIT   = 10,
  parameter int BLK_W      = $clog2(NUM_BLOCKS),
  parameter int PG_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic             reqErase,
  input  logic [BLK_W-1:0] reqBlock,
  input  logic [PG_W-1:0]  reqPage,
  input  logic [7:0]       reqCol,
  input  logic [7:0]       dataByte,
  input  logic [7:0]       busDin,
  output logic             limitHit,
  output logic             opErase,
  output logic [BLK_W-1:0] opBlock,
  output rspCode_e         code,
  output logic             busCle,
  output logic             busAle,
  output logic             busWe,
  output logic             busRe,
  output logic [7:0]       busDout
);

  localparam int ROW_BITS  = BLK_W + PG_W;
  localparam int NUM_PAGES = NUM_BLOCKS << PG_W;
  localparam int CNT_W     = $clog2(PP_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PP_LIMIT);

  logic [PG_W-1:0] opPage;
  logic [7:0]      opCol;
  logic [ROW_BITS-1:0] reqIdx;
  logic [CNT_W-1:0] pageCnt [NUM_PAGES];
  logic [15:0] progRow, eraseRow;
  logic [7:0]  cmdByte, addrByte, nextByte;

  assign reqIdx   = {reqBlock, reqPage};
  assign limitHit = (pageCnt[reqIdx] >= CNT_MAX);

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_cnt
    localparam logic [BLK_W-1:0] MY_BLK = BLK_W'(i >> PG_W);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pageCnt[i] <= '0;
      end else if (stb.wipe && reqBlock == MY_BLK) begin
        pageCnt[i] <= '0;
      end else if (stb.bump && reqIdx == ROW_BITS'(i)) begin
        pageCnt[i] <= pageCnt[i] + 1'b1;
      end
    end
  end

  always_comb begin
    progRow  = '0;
    eraseRow = '0;
    progRow[ROW_BITS-1:0]  = {opBlock, opPage};
    eraseRow[ROW_BITS-1:0] = {opBlock, {PG_W{1'b0}}};
  end

  always_comb begin
    unique case (stb.cmd)
      CMD_SETUP:   cmdByte = opErase ? OPC_ERASE_SETUP : OPC_PROG_SETUP;
      CMD_CONFIRM: cmdByte = opErase ? OPC_ERASE_GO : OPC_PROG_GO;
      default:     cmdByte = OPC_STATUS;
    endcase
    unique case (stb.addrIdx)
      2'd0:    addrByte = opErase ? eraseRow[7:0] : opCol;
      2'd1:    addrByte = opErase ? eraseRow[15:8] : progRow[7:0];
      default: addrByte = progRow[15:8];
    endcase
    unique case (stb.kind)
      BUS_CMD:  nextByte = cmdByte;
      BUS_ADDR: nextByte = addrByte;
      BUS_DATA: nextByte = dataByte;
      default:  nextByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opErase <= 1'b0;
      opBlock <= '0;
      opPage  <= '0;
      opCol   <= '0;
      code    <= RSP_PASS;
      busCle  <= 1'b0;
      busAle  <= 1'b0;
      busWe   <= 1'b0;
      busRe   <= 1'b0;
      busDout <= '0;
    end else begin
      if (stb.load) begin
        opErase <= reqErase;
        opBlock <= reqBlock;
        opPage  <= reqPage;
        opCol   <= reqCol;
      end
      if (stb.setReject) code <= stb.rejectCode;
      else if (busRe)    code <= busDin[0] ? RSP_FAIL : RSP_PASS;
      busWe   <= (stb.kind != BUS_IDLE);
      busCle  <= (stb.kind == BUS_CMD);
      busAle  <= (stb.kind == BUS_ADDR);
      busRe   <= stb.readStat;
      busDout <= nextByte;
    end
  end

endmodule

// File: rtl/nand_pe_seq.sv
module nand_pe_seq
  import nand_pe_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int PP_LIMIT   = 10,
  parameter int GUARD_CYC  = 2,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqErase,
  input  logic [BLK_W-1:0] reqBlock,
  input  logic [3:0]       reqPage,
  input  logic [7:0]       reqCol,
  input  logic             dataValid,
  output logic             dataReady,
  input  logic [7:0]       dataByte,
  input  logic             dataLast,
  output logic             busCle,
  output logic             busAle,
  output logic             busWe,
  output logic             busRe,
  output logic [7:0]       busDout,
  input  logic [7:0]       busDin,
  input  logic             nandRbN,
  input  logic             nandWpN,
  output logic             rspValid,
  output logic [1:0]       rspCode,
  output logic [BLK_W-1:0] rspBlock
);

  ctrlStrobe_t stb;
  logic limitHit, opErase;
  rspCode_e code;

  nand_pe_seq_ctrl #(.GUARD_CYC(GUARD_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqErase(reqErase),
    .wpN(nandWpN), .limitHit(limitHit), .opErase(opErase),
    .dataValid(dataValid), .dataLast(dataLast), .rbN(nandRbN),
    .reqReady(reqReady), .dataReady(dataReady), .rspValid(rspValid), .stb(stb)
  );

  nand_pe_seq_dp #(
    .NUM_BLOCKS(NUM_BLOCKS), .PP_LIMIT(PP_LIMIT), .BLK_W(BLK_W), .PG_W(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqErase(reqErase),
    .reqBlock(reqBlock), .reqPage(reqPage), .reqCol(reqCol),
    .dataByte(dataByte), .busDin(busDin), .limitHit(limitHit),
    .opErase(opErase), .opBlock(rspBlock), .code(code),
    .busCle(busCle), .busAle(busAle), .busWe(busWe), .busRe(busRe),
    .busDout(busDout)
  );

  assign rspCode = code;

endmodule

// File: rtl/nand_pe_seq_chk.sv
module nand_pe_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       dataReady,
  input logic       nandWpN,
  input logic       nandRbN,
  input logic       busWe,
  input logic       busCle,
  input logic       busAle,
  input logic       busRe,
  input logic [7:0] busDout,
  input logic       rspValid,
  input logic [1:0] rspCode
);

  p_quiet_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    !nandRbN |-> !busWe);

  p_read_after_status_r3: assert property (@(posedge clk) disable iff (!rstN)
    busRe |-> $past(busWe && busCle && busDout == 8'h70));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_wp_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !nandWpN) |=> (rspValid && rspCode == 2'd2));

  p_wp_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !nandWpN) |=> ##1 !busWe);

  p_ready_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataReady |-> !reqReady && !rspValid);

  p_latch_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> !(busCle && busAle));

endmodule

bind nand_pe_seq nand_pe_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .dataReady(dataReady), .nandWpN(nandWpN), .nandRbN(nandRbN),
  .busWe(busWe), .busCle(busCle), .busAle(busAle), .busRe(busRe),
  .busDout(busDout), .rspValid(rspValid), .rspCode(rspCode)
);

// File: tb/nand_pe_seq_tb.sv
module nand_pe_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 4;
  localparam int LOG_MAX = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqErase = 1'b0;
  logic [BLK_W-1:0] reqBlock = '0;
  logic [3:0] reqPage = '0;
  logic [7:0] reqCol = '0;
  logic dataValid = 1'b0, dataLast = 1'b0;
  logic [7:0] dataByte = '0;
  logic nandWpN = 1'b1;
  logic nandRbN;
  logic failFlag = 1'b0;
  logic [7:0] busDin;
  logic reqReady, dataReady, busCle, busAle, busWe, busRe, rspValid;
  logic [7:0] busDout;
  logic [1:0] rspCode;
  logic [BLK_W-1:0] rspBlock;

  int checks = 0, fails = 0, cycles = 0;
  int busyCnt = 0;
  int busyViol = 0;
  int logLen = 0;
  logic [9:0] busLog [LOG_MAX];
  logic [9:0] expLog [LOG_MAX];
  int refCnt [256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_pe_seq #(.NUM_BLOCKS(16)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqErase(reqErase), .reqBlock(reqBlock), .reqPage(reqPage),
    .reqCol(reqCol), .dataValid(dataValid), .dataReady(dataReady),
    .dataByte(dataByte), .dataLast(dataLast), .busCle(busCle),
    .busAle(busAle), .busWe(busWe), .busRe(busRe), .busDout(busDout),
    .busDin(busDin), .nandRbN(nandRbN), .nandWpN(nandWpN),
    .rspValid(rspValid), .rspCode(rspCode), .rspBlock(rspBlock)
  );

  assign busDin = {7'b1100000, failFlag};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nandRbN <= 1'b1;
      busyCnt <= 0;
    end else begin
      if (busWe) begin
        if (!nandRbN) busyViol <= busyViol + 1;
        if (logLen < LOG_MAX) busLog[logLen] <= {busCle, busAle, busDout};
        logLen <= logLen + 1;
      end
      if (busWe && busCle && (busDout == 8'h10 || busDout == 8'hD0)) begin
        nandRbN <= 1'b0;
        busyCnt <= 3 + int'($urandom % 12);
      end else if (busyCnt > 0) begin
        busyCnt <= busyCnt - 1;
        if (busyCnt == 1) nandRbN <= 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL R3 watchdog: cycles %0d expected below %0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] payload(input int i, input int salt);
    return 8'((i * 37 + salt * 11 + 5) & 255);
  endfunction

  function automatic int expectCode(input bit erase, input int idx, input bit wp, input bit fl);
    if (!wp) return 2;
    if (!erase && refCnt[idx] >= 10) return 3;
    return fl ? 1 : 0;
  endfunction

  task automatic feed(input int n, input int salt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dataValid = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
      dataValid = 1'b1;
      dataByte  = payload(i, salt);
      dataLast  = (i == n - 1);
      while (!dataReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    dataValid = 1'b0;
    dataLast  = 1'b0;
  endtask

  task automatic runOp(input bit erase, input int blk, input int pg, input int col,
                       input int n, input bit wp, input bit fl);
    int idx, expCode, expLen, gotCode, gotBlk, salt;
    string tagSeq;
    idx = blk * 16 + pg;
    salt = int'($urandom % 200);
    expCode = expectCode(erase, idx, wp, fl);
    expLen = 0;
    if (expCode < 2) begin
      logic [15:0] row;
      row = erase ? 16'(blk * 16) : 16'(idx);
      expLog[expLen++] = {2'b10, erase ? 8'h60 : 8'h80};
      if (!erase) expLog[expLen++] = {2'b01, 8'(col)};
      expLog[expLen++] = {2'b01, row[7:0]};
      expLog[expLen++] = {2'b01, row[15:8]};
      if (!erase) for (int i = 0; i < n; i++) expLog[expLen++] = {2'b00, payload(i, salt)};
      expLog[expLen++] = {2'b10, erase ? 8'hD0 : 8'h10};
      expLog[expLen++] = {2'b10, 8'h70};
    end
    @(negedge clk);
    nandWpN  = wp;
    failFlag = fl;
    logLen   = 0;
    reqValid = 1'b1;
    reqErase = erase;
    reqBlock = BLK_W'(blk);
    reqPage  = 4'(pg);
    reqCol   = 8'(col);
    chk(reqReady == 1'b1, "R10 idle ready before request", int'(reqReady), 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (expCode >= 2) begin
      chk(rspValid == 1'b1, expCode == 2 ? "R5 immediate response" : "R6 immediate response",
          int'(rspValid), 1);
    end else begin
      chk(reqReady == 1'b0, "R10 busy not ready", int'(reqReady), 0);
      if (!erase) feed(n, salt);
    end
    while (!rspValid) @(negedge clk);
    gotCode = int'(rspCode);
    gotBlk  = int'(rspBlock);
    chk(gotCode == expCode,
        expCode == 2 ? "R5 code" : (expCode == 3 ? "R6 code" : "R4 code"), gotCode, expCode);
    chk(gotBlk == blk, "R4 block", gotBlk, blk);
    @(negedge clk);
    chk(rspValid == 1'b0, "R4 single pulse", int'(rspValid), 0);
    nandWpN = 1'b1;
    repeat (2) @(negedge clk);
    tagSeq = (expCode >= 2) ? "R8 no bus on refusal" : (erase ? "R2 erase trace" : "R1 R9 program trace");
    chk(logLen == expLen, {tagSeq, " length"}, logLen, expLen);
    for (int i = 0; i < expLen && i < logLen; i++)
      if (busLog[i] !== expLog[i]) begin
        chk(1'b0, {tagSeq, " byte"}, int'(busLog[i]), int'(expLog[i]));
        break;
      end
    if (expCode < 2) begin
      if (erase) for (int p = 0; p < 16; p++) refCnt[blk * 16 + p] = 0;
      else refCnt[idx]++;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) refCnt[i] = 0;
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R10 reset ready", int'(reqReady), 1);
    chk(rspValid == 1'b0, "R4 reset no response", int'(rspValid), 0);
    chk(busWe == 1'b0, "R3 reset bus quiet", int'(busWe), 0);
    chk(dataReady == 1'b0, "R9 reset no data ready", int'(dataReady), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R6: ten programs of one page pass, eleventh is refused
    for (int k = 0; k < 10; k++) runOp(1'b0, 3, 7, k * 3, 2 + k % 4, 1'b1, 1'b0);
    runOp(1'b0, 3, 7, 0, 3, 1'b1, 1'b0);
    // R6: neighbour page unaffected
    runOp(1'b0, 3, 8, 9, 1, 1'b1, 1'b0);
    // R8: write-protected erase leaves the limit in place
    runOp(1'b1, 3, 0, 0, 0, 1'b0, 1'b0);
    runOp(1'b0, 3, 7, 0, 2, 1'b1, 1'b0);
    // R5: write-protected program
    runOp(1'b0, 2, 1, 4, 3, 1'b0, 1'b0);
    // R2 R4 R7: failing erase still clears counts
    runOp(1'b1, 3, 5, 0, 0, 1'b1, 1'b1);
    runOp(1'b0, 3, 7, 1, 2, 1'b1, 1'b0);
    // R4: program with failing status, highest block
    runOp(1'b0, 15, 15, 255, 5, 1'b1, 1'b1);
    // random mix over a few pages so limits recur
    for (int k = 0; k < 120; k++) begin
      bit er, wp, fl;
      er = ($urandom % 100) < 12;
      wp = ($urandom % 100) >= 8;
      fl = ($urandom % 100) < 20;
      runOp(er, int'($urandom % 2), int'($urandom % 2), int'($urandom % 256),
            1 + int'($urandom % 6), wp, fl);
    end
    chk(busyViol == 0, "R3 bus quiet while busy", busyViol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule